// File: doc/BRIEF.md
# Bioctal Paper Tape Word Packer

This block moves 36-bit machine words to and from seven-track paper tape frames in bioctal form. Its punch path takes one word and sends it out as six frames. Each frame holds two octal digits of the word in its six low tracks. Its reader path collects six frames and rebuilds the word. The seventh track carries no data: it marks where a word begins on the tape.

Each frame is one byte. Bit 7 is always zero. Bit 6 is the boundary mark, and bits 5..0 hold the digit pair. Frames travel most significant first: frame 0 holds word bits 35..30 and frame 5 holds bits 5..0. Both the word side and the frame side use a valid/ready handshake in each direction. The two paths are independent. A punched stream can be looped back into the reader without any glue logic.

Top module: `tape_bioctal_codec`

## Requirements
- R1: After a word is accepted (`pw_valid` and `pw_ready` high at a clock edge), the punch path presents six frames in turn. Frame k carries word bits (35-6k) down to (30-6k) in its bits 5..0.
- R2: Every punched frame has bit 7 at 0. Bit 6 (the boundary mark) is 1 on frame 0 of each word and 0 on frames 1 to 5.
- R3: `pw_ready` is 1 after reset. It is 0 from the cycle after a word is accepted until the cycle after the sixth frame has been taken (`pf_valid` and `pf_ready` high).
- R4: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` and `pf_byte` keep their values.
- R5: The reader path stores the bits 5..0 of six accepted frames in arrival order, with the first frame at the most significant end. It raises `rw_valid` with the assembled word in the cycle after the sixth frame is accepted, and not before.
- R6: An accepted frame with bit 6 set is treated as frame 0 of a new word, and any partly assembled word is discarded. This also holds when the marked frame arrives in the sixth position.
- R7: Bit 7 of an incoming frame has no effect. An unmarked frame that arrives right after a completed word counts as frame 0.
- R8: While `rw_valid` is 1, `rf_ready` is 0 and `rw_data` holds its value until `rw_ready` is seen. After that `rw_valid` falls and `rf_ready` returns to 1.
- R9: During reset `pf_valid` and `rw_valid` are 0, and `pw_ready` and `rf_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_valid | input | 1 | Word to punch is offered |
| pw_ready | output | 1 | Punch path can take a word |
| pw_data | input | 36 | Word to punch |
| pf_valid | output | 1 | Punched frame is offered |
| pf_ready | input | 1 | Downstream takes the punched frame |
| pf_byte | output | 8 | Punched frame: bit 6 mark, bits 5..0 digits |
| rf_valid | input | 1 | Read frame is offered |
| rf_ready | output | 1 | Reader path can take a frame |
| rf_byte | input | 8 | Read frame: bit 6 mark, bits 5..0 digits |
| rw_valid | output | 1 | Assembled word is offered |
| rw_ready | input | 1 | Consumer takes the assembled word |
| rw_data | output | 36 | Assembled word |

## Verification
The bench builds the block with its default parameters: a 36-bit word and six-bit digit pairs, so six frames per word. These are the only values the tape format allows. With them, the test reaches every frame position, including the last-frame counter wrap. It also covers a boundary mark arriving at the sixth position, where a complete word is abandoned one frame short. Word patterns with alternating, sparse and full digits show any slice that is shifted or swapped between frames.

// File: rtl/tape_pkg.sv
package tape_pkg;
    // byte that carries one tape frame
    localparam int FRAME_W  = 8;
    // track used as the word-boundary mark
    localparam int MARK_POS = 6;

    function automatic logic [FRAME_W-1:0] pack_frame(input logic mark, input logic [MARK_POS-1:0] bits);
        logic [FRAME_W-1:0] f;
        f = '0;
        f[MARK_POS] = mark;
        f[MARK_POS-1:0] = bits;
        return f;
    endfunction
endpackage

// File: rtl/tape_punch_ser.sv
module tape_punch_ser
    import tape_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int DIG_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               w_valid,
    output logic               w_ready,
    input  logic [WORD_W-1:0]  w_data,
    output logic               f_valid,
    input  logic               f_ready,
    output logic [FRAME_W-1:0] f_byte
);
    localparam int FRAMES = WORD_W / DIG_W;
    localparam int IDX_W  = $clog2(FRAMES);
    localparam int CNT_W  = $clog2(FRAMES + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (w_valid) begin
                st_d.busy = 1'b1;
                st_d.sh   = w_data;
                st_d.idx  = '0;
            end
        end else if (f_ready) begin
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.sh  = st_q.sh << DIG_W;
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [MARK_POS-1:0] digs;
    always_comb begin
        digs = '0;
        digs[DIG_W-1:0] = st_q.sh[WORD_W-1 -: DIG_W];
    end

    assign w_ready = !st_q.busy;
    assign f_valid = st_q.busy;
    assign f_byte  = pack_frame(st_q.idx == '0, digs);

    // frame count since the last word accept, for the checks below
    logic [CNT_W-1:0] sent_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                sent_q <= '0;
        else if (w_valid && w_ready) sent_q <= '0;
        else if (f_valid && f_ready) sent_q <= sent_q + 1'b1;
    end

    // R3
    six_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_ready) |-> sent_q == CNT_W'(FRAMES));
    // R4
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid && !f_ready |=> f_valid && $stable(f_byte));
    // R2
    mark_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready |=> f_valid && f_byte[MARK_POS]);
    // R2
    mark_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid && f_ready && f_byte[MARK_POS] |=> f_valid && !f_byte[MARK_POS]);
endmodule

// File: rtl/tape_read_asm.sv
module tape_read_asm
    import tape_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int DIG_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               f_valid,
    output logic               f_ready,
    input  logic [FRAME_W-1:0] f_byte,
    output logic               w_valid,
    input  logic               w_ready,
    output logic [WORD_W-1:0]  w_data
);
    localparam int FRAMES = WORD_W / DIG_W;
    localparam int IDX_W  = $clog2(FRAMES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    typedef struct packed {
        logic              hold;
        logic [WORD_W-1:0] acc;
        logic [IDX_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;

    logic [DIG_W-1:0] digs;
    logic             mark;
    assign digs = f_byte[DIG_W-1:0];
    assign mark = f_byte[MARK_POS];

    logic unused_bits;
    assign unused_bits = ^f_byte[FRAME_W-1:MARK_POS+1];

    always_comb begin
        st_d = st_q;
        if (st_q.hold) begin
            if (w_ready) st_d.hold = 1'b0;
        end else if (f_valid) begin
            if (mark) begin
                st_d.acc = {{(WORD_W-DIG_W){1'b0}}, digs};
                st_d.cnt = IDX_W'(1);
            end else begin
                st_d.acc = {st_q.acc[WORD_W-DIG_W-1:0], digs};
                if (st_q.cnt == LAST) begin
                    st_d.cnt  = '0;
                    st_d.hold = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign f_ready = !st_q.hold;
    assign w_valid = st_q.hold;
    assign w_data  = st_q.acc;

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_data));
    // R6
    mark_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid && f_ready && f_byte[MARK_POS] |=> !w_valid);
    // R8
    taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready |=> !w_valid && f_ready);
endmodule

// File: rtl/tape_bioctal_codec.sv
module tape_bioctal_codec
    import tape_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int DIG_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pw_valid,
    output logic               pw_ready,
    input  logic [WORD_W-1:0]  pw_data,
    output logic               pf_valid,
    input  logic               pf_ready,
    output logic [FRAME_W-1:0] pf_byte,
    input  logic               rf_valid,
    output logic               rf_ready,
    input  logic [FRAME_W-1:0] rf_byte,
    output logic               rw_valid,
    input  logic               rw_ready,
    output logic [WORD_W-1:0]  rw_data
);
    tape_punch_ser #(.WORD_W(WORD_W), .DIG_W(DIG_W)) u_punch (
        .clk(clk), .rst_n(rst_n),
        .w_valid(pw_valid), .w_ready(pw_ready), .w_data(pw_data),
        .f_valid(pf_valid), .f_ready(pf_ready), .f_byte(pf_byte)
    );

    tape_read_asm #(.WORD_W(WORD_W), .DIG_W(DIG_W)) u_read (
        .clk(clk), .rst_n(rst_n),
        .f_valid(rf_valid), .f_ready(rf_ready), .f_byte(rf_byte),
        .w_valid(rw_valid), .w_ready(rw_ready), .w_data(rw_data)
    );

    // R2
    top_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !pf_byte[FRAME_W-1]);
endmodule

// File: tb/tape_bioctal_codec_tb.sv
module tape_bioctal_codec_tb;
    localparam int NF = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        pw_valid = 1'b0, pw_ready;
    logic [35:0] pw_data = '0;
    logic        pf_valid, pf_ready = 1'b0;
    logic [7:0]  pf_byte;
    logic        rf_valid = 1'b0, rf_ready;
    logic [7:0]  rf_byte = '0;
    logic        rw_valid, rw_ready = 1'b0;
    logic [35:0] rw_data;

    tape_bioctal_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_data(pw_data),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_byte(pf_byte),
        .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_byte(rf_byte),
        .rw_valid(rw_valid), .rw_ready(rw_ready), .rw_data(rw_data)
    );

    int checks = 0;
    int fails  = 0;

    localparam logic [35:0] VEC [6] = '{
        36'o777777777777, 36'o000000000000, 36'o123456701234,
        36'o525252525252, 36'o400000000001, 36'o070707070707
    };

    logic [7:0] cap [NF];

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%o expected=%o", req, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_of(input logic [35:0] w, input int k, input logic mark);
        return {1'b0, mark, w[35-6*k -: 6]};
    endfunction

    // all tasks start and end just after a falling edge
    task automatic punch(input logic [35:0] w, input bit stall);
        logic [7:0] exp;
        chk(pw_ready == 1'b1, "R3", 36'(pw_ready), 36'd1);
        pw_valid = 1'b1; pw_data = w;
        @(negedge clk);
        pw_valid = 1'b0; pw_data = '0;
        chk(pw_ready == 1'b0, "R3", 36'(pw_ready), 36'd0);
        for (int k = 0; k < NF; k++) begin
            exp = frame_of(w, k, k == 0);
            if (stall && k == 2) begin
                pf_ready = 1'b0;
                @(negedge clk);
                chk(pf_valid && pf_byte == exp, "R4", 36'(pf_byte), 36'(exp));
                @(negedge clk);
                chk(pf_valid && pf_byte == exp, "R4", 36'(pf_byte), 36'(exp));
            end
            chk(pf_valid && pf_byte[5:0] == exp[5:0], "R1", 36'(pf_byte), 36'(exp));
            chk(pf_byte[7:6] == exp[7:6], "R2", 36'(pf_byte[7:6]), 36'(exp[7:6]));
            if (k > 0) chk(pw_ready == 1'b0, "R3", 36'(pw_ready), 36'd0);
            cap[k] = pf_byte;
            pf_ready = 1'b1;
            @(negedge clk);
            pf_ready = 1'b0;
        end
        chk(!pf_valid && pw_ready, "R3", 36'({pf_valid, pw_ready}), 36'b01);
    endtask

    task automatic send(input logic [7:0] b);
        chk(rf_ready == 1'b1, "R8", 36'(rf_ready), 36'd1);
        rf_valid = 1'b1; rf_byte = b;
        @(negedge clk);
        rf_valid = 1'b0; rf_byte = '0;
    endtask

    task automatic send_word(input logic [35:0] w, input logic [7:0] extra);
        for (int k = 0; k < NF; k++) send(frame_of(w, k, k == 0) | extra);
    endtask

    task automatic take(input logic [35:0] exp, input string req);
        chk(rw_valid == 1'b1, req, 36'(rw_valid), 36'd1);
        chk(rw_data == exp, req, rw_data, exp);
        rw_ready = 1'b1;
        @(negedge clk);
        rw_ready = 1'b0;
        chk(!rw_valid && rf_ready, "R8", 36'({rw_valid, rf_ready}), 36'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!pf_valid && !rw_valid, "R9", 36'({pf_valid, rw_valid}), 36'd0);
        chk(pw_ready && rf_ready, "R9", 36'({pw_ready, rf_ready}), 36'b11);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: punch each word, loop its frames into the reader
        for (int i = 0; i < 6; i++) begin
            punch(VEC[i], i == 1);
            for (int k = 0; k < NF; k++) begin
                send(cap[k]);
                if (k < NF - 1) chk(rw_valid == 1'b0, "R5", 36'(rw_valid), 36'd0);
            end
            take(VEC[i], "R5");
        end

        // R8: held word blocks frames and stays stable
        send_word(VEC[2], 8'h00);
        repeat (2) begin
            @(negedge clk);
            chk(rw_valid && !rf_ready, "R8", 36'({rw_valid, rf_ready}), 36'b10);
            chk(rw_data == VEC[2], "R8", rw_data, VEC[2]);
        end
        take(VEC[2], "R8");

        // R6: marked frame mid-word discards the partial word
        for (int k = 0; k < 3; k++) send(frame_of(VEC[3], k, k == 0));
        send_word(VEC[4], 8'h00);
        take(VEC[4], "R6");

        // R6: marked frame in the sixth position restarts
        for (int k = 0; k < 5; k++) send(frame_of(VEC[0], k, k == 0));
        send(frame_of(VEC[5], 0, 1'b1));
        chk(rw_valid == 1'b0, "R6", 36'(rw_valid), 36'd0);
        for (int k = 1; k < NF; k++) send(frame_of(VEC[5], k, 1'b0));
        take(VEC[5], "R6");

        // R7: bit 7 set on every frame has no effect
        send_word(VEC[2], 8'h80);
        take(VEC[2], "R7");

        // R7: unmarked first frame after a completed word
        for (int k = 0; k < NF; k++) send(frame_of(VEC[3], k, 1'b0));
        take(VEC[3], "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule